// File: doc/BRIEF.md
# Latched Second-Level Interrupt Aggregator

This block gathers 32 interrupt sources behind a small register interface and presents one combined request to a parent interrupt controller. Each source has a pending bit and a mask bit. Software changes the mask only through separate write-one-to-set and write-one-to-clear registers, and reads the mask back through a read-only view. The combined request is high while any pending bit is not masked.

A parameter picks one of two variants. In the latched variant, each rising edge on a source sets a sticky pending bit, and software writes ones to a clear register to remove it. In the level variant, the pending view is the live input level and there is no clear register. The two variants place their registers at different offsets. Register reads are combinational. Writes take effect at the next clock edge.

Top module: `l2irq_agg`

## Requirements
- R1: The block serves 32 sources, one bit per source in every 32-bit register. The latched variant (LATCHED=1) decodes status 0x00, clear 0x08, mask view 0x0C, mask set 0x10 and mask clear 0x14. The level variant (LATCHED=0) decodes status 0x00, mask view 0x04, mask set 0x08 and mask clear 0x0C. The set and clear registers read as zero.
- R2: While reset is low and after it, the mask reads all ones, every latched pending bit reads zero and irqOut is low.
- R3: Writing ones to the mask set register masks those sources (mask bit 1 = masked). Zero bits leave their mask bits unchanged, and writing all ones masks every source.
- R4: Writing ones to the mask clear register unmasks those sources. Zero bits leave their mask bits unchanged.
- R5: In the latched variant, a 0-to-1 change on a source input sets its pending bit at the next clock edge. The bit stays set after the input falls.
- R6: In the latched variant, writing ones to the clear register clears those pending bits and zero bits have no effect. Writing all ones empties every pending bit.
- R7: In the latched variant, when a rising edge and a clear write hit the same bit in the same cycle, the bit stays set.
- R8: A masked source still records its pending bit. irqOut rises once that source is unmasked.
- R9: irqOut is high exactly when some bit of (pending AND NOT mask) is 1.
- R10: In the level variant, the status register reads the live source inputs, writes to it have no effect, and irqOut follows the inputs with no clock delay.
- R11: Reads of offsets outside the variant's map return zero. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | NUM_SRC | Interrupt source inputs |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register access |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for addr (combinational) |
| irqOut | output | 1 | Combined request to the parent controller |

## Verification
The bench builds two copies side by side, one with LATCHED=1 and one with LATCHED=0. Both copies see the same source inputs. The latched copy brings sticky capture, write-one-to-clear, the edge-versus-clear race and the wider offset map within reach. The level copy exercises the shorter map, the live status view, the ignored status writes, and the way offsets 0x10 and 0x14 become unmapped when the clear register is absent.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;
  // Write strobes from register decode to the storage datapath.
  typedef struct packed {
    logic statClr;
    logic maskSet;
    logic maskClr;
  } wrStrobe_t;
endpackage

// File: rtl/l2irq_ctrl.sv
module l2irq_ctrl
  import l2irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter bit LATCHED = 1'b1
) (
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] statusVec,
  input  logic [NUM_SRC-1:0] maskVec,
  output wrStrobe_t          strb,
  output logic [DATA_W-1:0]  rdData
);
  // Offsets shift with the variant; the level map has no clear register.
  localparam logic [ADDR_W-1:0] OFF_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_CLEAR  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_MASK   = ADDR_W'(LATCHED ? 12 : 4);
  localparam logic [ADDR_W-1:0] OFF_SET    = ADDR_W'(LATCHED ? 16 : 8);
  localparam logic [ADDR_W-1:0] OFF_UNSET  = ADDR_W'(LATCHED ? 20 : 12);

  always_comb begin
    strb.statClr = LATCHED && wrEn && (addr == OFF_CLEAR);
    strb.maskSet = wrEn && (addr == OFF_SET);
    strb.maskClr = wrEn && (addr == OFF_UNSET);
  end

  // Write-only and unmapped offsets read as zero (R1, R11).
  always_comb begin
    rdData = '0;
    if (addr == OFF_STATUS)    rdData = DATA_W'(statusVec);
    else if (addr == OFF_MASK) rdData = DATA_W'(maskVec);
  end
endmodule

// File: rtl/l2irq_datapath.sv
module l2irq_datapath
  import l2irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter bit LATCHED = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  wrStrobe_t          strb,
  input  logic [NUM_SRC-1:0] wrBits,
  output logic [NUM_SRC-1:0] statusVec,
  output logic [NUM_SRC-1:0] maskVec,
  output logic               irqOut
);
  logic [NUM_SRC-1:0] maskQ;

  // Mask resets to all ones: every source disabled (R2, R3, R4).
  always_ff @(posedge clk) begin
    if (!rstN)             maskQ <= '1;
    else if (strb.maskSet) maskQ <= maskQ | wrBits;
    else if (strb.maskClr) maskQ <= maskQ & ~wrBits;
  end

  generate
    if (LATCHED) begin : g_latched
      logic [NUM_SRC-1:0] prevQ;
      logic [NUM_SRC-1:0] statQ;
      logic [NUM_SRC-1:0] clrBits;
      logic [NUM_SRC-1:0] riseBits;
      assign clrBits  = strb.statClr ? wrBits : '0;
      assign riseBits = srcIn & ~prevQ;
      // A new edge is ORed in after the clear, so it survives a same-cycle clear (R7).
      always_ff @(posedge clk) begin
        if (!rstN) begin
          prevQ <= '0;
          statQ <= '0;
        end else begin
          prevQ <= srcIn;
          statQ <= (statQ & ~clrBits) | riseBits;
        end
      end
      assign statusVec = statQ;
    end else begin : g_level
      logic unusedClr;
      assign unusedClr = strb.statClr;
      assign statusVec = srcIn;
    end
  endgenerate

  assign maskVec = maskQ;
  assign irqOut  = |(statusVec & ~maskQ);
endmodule

// File: rtl/l2irq_agg.sv
module l2irq_agg
  import l2irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter bit LATCHED = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  wrStrobe_t          strb;
  logic [NUM_SRC-1:0] statusVec;
  logic [NUM_SRC-1:0] maskVec;

  l2irq_ctrl #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LATCHED(LATCHED)) u_ctrl (
    .wrEn(wrEn), .addr(addr), .statusVec(statusVec), .maskVec(maskVec),
    .strb(strb), .rdData(rdData)
  );

  l2irq_datapath #(.NUM_SRC(NUM_SRC), .LATCHED(LATCHED)) u_dp (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .strb(strb),
    .wrBits(wrData[NUM_SRC-1:0]), .statusVec(statusVec), .maskVec(maskVec),
    .irqOut(irqOut)
  );
endmodule

// File: rtl/l2irq_agg_chk.sv
module l2irq_agg_chk #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter bit LATCHED = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcIn,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wrData,
  input logic [NUM_SRC-1:0] statusVec,
  input logic [NUM_SRC-1:0] maskVec,
  input logic               irqOut
);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(LATCHED ? 16 : 8);
  localparam logic [ADDR_W-1:0] A_UNSET = ADDR_W'(LATCHED ? 20 : 12);

  logic [NUM_SRC-1:0] wBits;
  assign wBits = wrData[NUM_SRC-1:0];

  p_mask_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_SET) |=> ((maskVec & $past(wBits)) == $past(wBits)));

  p_mask_clr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_UNSET) |=> ((maskVec & $past(wBits)) == '0));

  p_mask_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (addr == A_SET || addr == A_UNSET)) |=> $stable(maskVec));

  p_all_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec == '1) |-> !irqOut);

  generate
    if (LATCHED) begin : g_lat_chk
      logic [NUM_SRC-1:0] seenQ;
      logic [NUM_SRC-1:0] riseC;
      always_ff @(posedge clk) begin
        if (!rstN) seenQ <= '0;
        else       seenQ <= srcIn;
      end
      assign riseC = srcIn & ~seenQ;

      p_edge_sticks_r7: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> ((statusVec & $past(riseC)) == $past(riseC)));

      p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn && addr == A_CLR) |=> ((statusVec & $past(wBits & ~riseC)) == '0));
    end
  endgenerate
endmodule

bind l2irq_agg l2irq_agg_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LATCHED(LATCHED)
) u_chk (
  .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEn), .addr(addr),
  .wrData(wrData), .statusVec(statusVec), .maskVec(maskVec), .irqOut(irqOut)
);

// File: tb/l2irq_agg_bench.sv
module l2irq_agg_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic        wrEnL = 1'b0;
  logic        wrEnV = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdL, rdV;
  logic        irqL, irqV;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  l2irq_agg #(.LATCHED(1'b1)) u_l2irq_agg (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEnL), .addr(addr),
    .wrData(wrData), .rdData(rdL), .irqOut(irqL));

  l2irq_agg #(.LATCHED(1'b0)) u_l2irq_agg_lvl (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .wrEn(wrEnV), .addr(addr),
    .wrData(wrData), .rdData(rdV), .irqOut(irqV));

  // Vector: {op[1:0], addr[7:0], data[31:0], req[3:0]}; op 0 write, 1 read-check, 2 drive sources.
  localparam int NV = 17;
  localparam logic [45:0] VEC [NV] = '{
    {2'd1, 8'h0C, 32'hFFFF_FFFF, 4'd2},  // R2 mask after reset
    {2'd1, 8'h00, 32'h0000_0000, 4'd2},  // R2 status after reset
    {2'd2, 8'h00, 32'h0000_00A5, 4'd5},
    {2'd1, 8'h00, 32'h0000_00A5, 4'd5},  // R5 capture
    {2'd2, 8'h00, 32'h0000_0000, 4'd5},
    {2'd1, 8'h00, 32'h0000_00A5, 4'd5},  // R5 sticky
    {2'd0, 8'h08, 32'h0000_0005, 4'd6},
    {2'd1, 8'h00, 32'h0000_00A0, 4'd6},  // R6 partial clear
    {2'd0, 8'h14, 32'h0000_00F0, 4'd4},
    {2'd1, 8'h0C, 32'hFFFF_FF0F, 4'd4},  // R4 unmask
    {2'd0, 8'h10, 32'h0000_0030, 4'd3},
    {2'd1, 8'h0C, 32'hFFFF_FF3F, 4'd3},  // R3 mask set
    {2'd1, 8'h04, 32'h0000_0000, 4'd11}, // R11 unmapped read
    {2'd1, 8'h10, 32'h0000_0000, 4'd1},  // R1 set register reads zero
    {2'd0, 8'h18, 32'hFFFF_FFFF, 4'd11},
    {2'd1, 8'h0C, 32'hFFFF_FF3F, 4'd11}, // R11 unmapped write ignored
    {2'd0, 8'h08, 32'hFFFF_FFFF, 4'd6}   // R6 clear all (checked below)
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wrBus(input bit lvl, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d;
    if (lvl) wrEnV = 1'b1; else wrEnL = 1'b1;
    @(negedge clk);
    wrEnL = 1'b0; wrEnV = 1'b0;
  endtask

  task automatic rdBus(input bit lvl, input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1;
    v = lvl ? rdV : rdL;
  endtask

  task automatic drv(input logic [31:0] v);
    @(negedge clk);
    srcIn = v;
    @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual expired expected completion");
      finishRun();
    end
  end

  initial begin : stim
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R2 irq after reset", {31'd0, irqL}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][45:44])
        2'd0: wrBus(1'b0, VEC[i][43:36], VEC[i][35:4]);
        2'd1: begin
          rdBus(1'b0, VEC[i][43:36], v);
          check($sformatf("R%0d table %0d", VEC[i][3:0], i), v, VEC[i][35:4]);
        end
        default: drv(VEC[i][35:4]);
      endcase
    end
    rdBus(1'b0, 8'h00, v); check("R6 clear all", v, 32'h0);

    // R9: unmasked edge drives irq; clearing drops it
    drv(32'h40);
    check("R9 irq on unmasked pending", {31'd0, irqL}, 32'd1);
    wrBus(1'b0, 8'h08, 32'h40);
    check("R6 R9 irq after clear", {31'd0, irqL}, 32'd0);

    // R8: masked source still latches
    drv(32'h41);
    rdBus(1'b0, 8'h00, v); check("R8 masked latch", v, 32'h1);
    check("R8 irq while masked", {31'd0, irqL}, 32'd0);
    wrBus(1'b0, 8'h14, 32'h1);
    check("R8 irq after unmask", {31'd0, irqL}, 32'd1);
    wrBus(1'b0, 8'h10, 32'hFFFF_FFFF);
    check("R3 mask all quiets irq", {31'd0, irqL}, 32'd0);
    rdBus(1'b0, 8'h0C, v); check("R3 mask all ones", v, 32'hFFFF_FFFF);

    // R7: edge and clear in the same cycle
    drv(32'h43);
    drv(32'h41);
    rdBus(1'b0, 8'h00, v); check("R5 bit1 held", v, 32'h3);
    @(negedge clk);
    addr = 8'h08; wrData = 32'h2; wrEnL = 1'b1; srcIn = 32'h43;
    @(negedge clk);
    wrEnL = 1'b0;
    rdBus(1'b0, 8'h00, v); check("R7 edge beats clear", v, 32'h3);
    wrBus(1'b0, 8'h08, 32'h2);
    rdBus(1'b0, 8'h00, v); check("R6 clear without edge", v, 32'h1);

    // R10: level variant
    rdBus(1'b1, 8'h04, v); check("R2 R10 level mask view", v, 32'hFFFF_FFFF);
    rdBus(1'b1, 8'h00, v); check("R10 live status", v, 32'h43);
    wrBus(1'b1, 8'h00, 32'hFFFF_FFFF);
    rdBus(1'b1, 8'h00, v); check("R10 status write ignored", v, 32'h43);
    wrBus(1'b1, 8'h10, 32'hFFFF_FFFF);
    rdBus(1'b1, 8'h04, v); check("R11 level unmapped write", v, 32'hFFFF_FFFF);
    rdBus(1'b1, 8'h14, v); check("R11 level unmapped read", v, 32'h0);
    wrBus(1'b1, 8'h0C, 32'h1);
    rdBus(1'b1, 8'h04, v); check("R4 level unmask", v, 32'hFFFF_FFFE);
    check("R9 level irq", {31'd0, irqV}, 32'd1);
    @(negedge clk);
    srcIn = 32'h42;
    #1;
    check("R10 level irq follows input", {31'd0, irqV}, 32'd0);

    // R2: reset mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rdBus(1'b0, 8'h00, v); check("R2 status in reset", v, 32'h0);
    rdBus(1'b0, 8'h0C, v); check("R2 mask in reset", v, 32'hFFFF_FFFF);
    check("R2 irq in reset", {31'd0, irqL}, 32'd0);
    finishRun();
  end
endmodule